// File: doc/BRIEF.md
# Immediate-Arithmetic and Jump-and-Link Instruction Decoder

This block is a purely combinational decoder for 32-bit base-integer instruction words. It splits out the register selectors and the three-bit function field for any word. It also forms a sign-extended immediate and drives the control strobes that the datapath of a single-cycle core needs.

Two instructions are recognised: add-immediate, from the immediate-arithmetic opcode, and jump-and-link. For the jump, the decoder gathers the offset bits from the places where they are scattered across the word. The offset's lowest bit is implied and always zero, and the result is sign-extended into a byte offset.

Every other word, including the remaining function codes of the immediate-arithmetic opcode, is treated as unrecognised. Such a word writes no register and does not redirect the program counter. A core uses the outputs in the same cycle to steer its register file, its ALU operand multiplexers, its write-back multiplexer and its program-counter load.

Top module: `instr_decoder_ij`

## Requirements
- R1: For any instruction word, `rd_sel_o` equals bits 11:7, `funct3_o` equals bits 14:12, `rs1_sel_o` equals bits 19:15 and `rs2_sel_o` equals bits 24:20.
- R2: Opcode 7'b0010011 with function field 3'b000 is add-immediate. It gives `reg_we_o`=1, `pc_load_o`=0, `alu_a_sel_o`=0 (register operand), `alu_b_sel_o`=1 (immediate operand) and `wb_sel_o`=0 (ALU result).
- R3: When the opcode is not 7'b1101111, `imm_o` is bits 31:20 sign-extended to XLEN bits.
- R4: Opcode 7'b1101111 is jump-and-link. It gives `reg_we_o`=1, `pc_load_o`=1, `alu_a_sel_o`=1 (program counter), `alu_b_sel_o`=1 (immediate) and `wb_sel_o`=1 (PC+4).
- R5: For jump-and-link, `imm_o` is the signed offset whose bit 20 is word bit 31, bits 19:12 are word bits 19:12, bit 11 is word bit 20, bits 10:1 are word bits 30:21 and bit 0 is zero. It is sign-extended from offset bit 20.
- R6: A jump-and-link word carrying the 21-bit offset 0x1FFFFC (word 0xFFDFF06F with rd=0) yields `imm_o` = 0xFFFFFFFC, which is -4.
- R7: Opcode 7'b0010011 with any function field other than 3'b000 is unrecognised: all five control outputs are 0.
- R8: Any opcode other than the two above drives all five control outputs to 0.
- R9: Jump-and-link is recognised from the opcode alone, whatever the value of bits 14:12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| rs1_sel_o | output | 5 | First source register selector |
| rs2_sel_o | output | 5 | Second source register selector |
| rd_sel_o | output | 5 | Destination register selector |
| funct3_o | output | 3 | Three-bit function field |
| imm_o | output | XLEN | Sign-extended immediate |
| reg_we_o | output | 1 | Register file write enable |
| pc_load_o | output | 1 | Program counter loads the ALU result instead of incrementing |
| alu_a_sel_o | output | 1 | ALU operand A: 0 register, 1 program counter |
| alu_b_sel_o | output | 1 | ALU operand B: 0 register, 1 immediate |
| wb_sel_o | output | 1 | Write-back data: 0 ALU result, 1 PC+4 |

## Verification
The bench builds the decoder with its default XLEN of 32. At this width the full 4096-value add-immediate field, every one of the 1024 opcode and function-field pairs, and every single-bit jump offset can each be swept. Jump offsets are produced by encoding a chosen byte offset into the scattered layout and checking that the decoder returns it. This covers both sign extremes and the -4 loop-back case, together with a stream of pseudo-random even offsets.

// File: rtl/ij_dec_pkg.sv
package ij_dec_pkg;
    localparam int ILEN   = 32;
    localparam int OPC_W  = 7;
    localparam int RSEL_W = 5;
    localparam int F3_W   = 3;
    localparam int IIMM_W = 12;
    localparam int JIMM_W = 21;

    localparam logic [OPC_W-1:0] OPC_OPIMM = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_JAL   = 7'b1101111;
    localparam logic [F3_W-1:0]  F3_ADDI   = 3'b000;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_ADDI = 2'd1,
        CLS_JAL  = 2'd2
    } insn_class_e;

    typedef enum logic {
        OPA_RS1 = 1'b0,
        OPA_PC  = 1'b1
    } opa_sel_e;

    typedef enum logic {
        OPB_RS2 = 1'b0,
        OPB_IMM = 1'b1
    } opb_sel_e;

    typedef enum logic {
        WB_ALU = 1'b0,
        WB_PC4 = 1'b1
    } wb_sel_e;

    typedef struct packed {
        logic     reg_we;
        logic     pc_load;
        opa_sel_e opa;
        opb_sel_e opb;
        wb_sel_e  wb;
    } ctrl_t;
endpackage

// File: rtl/ij_class_decode.sv
module ij_class_decode
    import ij_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [F3_W-1:0]  funct3_i,
    output insn_class_e      cls_o
);
    always_comb begin
        cls_o = CLS_NONE;
        unique case (opcode_i)
            OPC_JAL:   cls_o = CLS_JAL;
            OPC_OPIMM: cls_o = (funct3_i == F3_ADDI) ? CLS_ADDI : CLS_NONE;
            default:   cls_o = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/ij_ctrl_gen.sv
module ij_ctrl_gen
    import ij_dec_pkg::*;
(
    input  insn_class_e cls_i,
    output ctrl_t       ctrl_o
);
    always_comb begin
        ctrl_o = '{reg_we: 1'b0, pc_load: 1'b0, opa: OPA_RS1, opb: OPB_RS2, wb: WB_ALU};
        unique case (cls_i)
            CLS_ADDI: ctrl_o = '{reg_we: 1'b1, pc_load: 1'b0, opa: OPA_RS1, opb: OPB_IMM, wb: WB_ALU};
            CLS_JAL:  ctrl_o = '{reg_we: 1'b1, pc_load: 1'b1, opa: OPA_PC,  opb: OPB_IMM, wb: WB_PC4};
            default:  ctrl_o = '{reg_we: 1'b0, pc_load: 1'b0, opa: OPA_RS1, opb: OPB_RS2, wb: WB_ALU};
        endcase
    end
endmodule

// File: rtl/ij_imm_build.sv
module ij_imm_build
    import ij_dec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] instr_i,
    input  logic            jump_fmt_i,
    output logic [XLEN-1:0] imm_o
);
    localparam int I_EXT = XLEN - IIMM_W;
    localparam int J_EXT = XLEN - JIMM_W;

    logic [IIMM_W-1:0] i_raw;
    logic [JIMM_W-1:0] j_raw;
    logic [XLEN-1:0]   i_full;
    logic [XLEN-1:0]   j_full;

    assign i_raw = instr_i[31:20];
    // reassemble the scattered jump offset; lowest bit is implied zero
    assign j_raw = {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};

    generate
        if (J_EXT > 0) begin : g_jext
            assign j_full = {{J_EXT{j_raw[JIMM_W-1]}}, j_raw};
        end else begin : g_jfit
            assign j_full = j_raw[XLEN-1:0];
        end
    endgenerate

    assign i_full = {{I_EXT{i_raw[IIMM_W-1]}}, i_raw};
    assign imm_o  = jump_fmt_i ? j_full : i_full;
endmodule

// File: rtl/instr_decoder_ij.sv
module instr_decoder_ij
    import ij_dec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr_i,
    output logic [4:0]      rs1_sel_o,
    output logic [4:0]      rs2_sel_o,
    output logic [4:0]      rd_sel_o,
    output logic [2:0]      funct3_o,
    output logic [XLEN-1:0] imm_o,
    output logic            reg_we_o,
    output logic            pc_load_o,
    output logic            alu_a_sel_o,
    output logic            alu_b_sel_o,
    output logic            wb_sel_o
);
    insn_class_e cls;
    ctrl_t       ctrl;

    assign rd_sel_o  = instr_i[11:7];
    assign funct3_o  = instr_i[14:12];
    assign rs1_sel_o = instr_i[19:15];
    assign rs2_sel_o = instr_i[24:20];

    ij_class_decode u_class (
        .opcode_i (instr_i[6:0]),
        .funct3_i (instr_i[14:12]),
        .cls_o    (cls)
    );

    ij_ctrl_gen u_ctrl (
        .cls_i  (cls),
        .ctrl_o (ctrl)
    );

    ij_imm_build #(.XLEN(XLEN)) u_imm (
        .instr_i    (instr_i),
        .jump_fmt_i (instr_i[6:0] == OPC_JAL),
        .imm_o      (imm_o)
    );

    assign reg_we_o    = ctrl.reg_we;
    assign pc_load_o   = ctrl.pc_load;
    assign alu_a_sel_o = ctrl.opa;
    assign alu_b_sel_o = ctrl.opb;
    assign wb_sel_o    = ctrl.wb;
endmodule

// File: rtl/instr_decoder_ij_chk.sv
module instr_decoder_ij_chk #(
    parameter int XLEN = 32
) (
    input logic [31:0]     instr_i,
    input logic [XLEN-1:0] imm_o,
    input logic            reg_we_o,
    input logic            pc_load_o,
    input logic            alu_a_sel_o,
    input logic            alu_b_sel_o,
    input logic            wb_sel_o
);
    logic is_jal;
    logic is_addi;
    assign is_jal  = (instr_i[6:0] == 7'b1101111);
    assign is_addi = (instr_i[6:0] == 7'b0010011) && (instr_i[14:12] == 3'b000);

    always_comb begin
        if (!$isunknown(instr_i)) begin
            p_jal_strobes_r4: assert (!is_jal || (reg_we_o && pc_load_o && alu_a_sel_o && wb_sel_o))
                else $error("jump strobes wrong");
            p_jal_any_f3_r9: assert (!is_jal || pc_load_o)
                else $error("jump not recognised");
            p_pcload_src_r8: assert (!pc_load_o || is_jal)
                else $error("program counter load without jump");
            p_write_src_r7: assert (!reg_we_o || is_jal || is_addi)
                else $error("write from unrecognised word");
            p_jal_even_r5: assert (!is_jal || !imm_o[0])
                else $error("jump offset odd");
            p_sign_fill_r3: assert (imm_o[XLEN-1:20] == {(XLEN-20){instr_i[31]}})
                else $error("immediate sign fill wrong");
            p_addi_ops_r2: assert (!is_addi || (alu_b_sel_o && !alu_a_sel_o && !wb_sel_o && !pc_load_o))
                else $error("add-immediate selects wrong");
        end
    end
endmodule

bind instr_decoder_ij instr_decoder_ij_chk #(.XLEN(XLEN)) u_chk (
    .instr_i     (instr_i),
    .imm_o       (imm_o),
    .reg_we_o    (reg_we_o),
    .pc_load_o   (pc_load_o),
    .alu_a_sel_o (alu_a_sel_o),
    .alu_b_sel_o (alu_b_sel_o),
    .wb_sel_o    (wb_sel_o)
);

// File: tb/instr_decoder_ij_test.sv
module instr_decoder_ij_test;
    logic        clk = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [4:0]  rs1, rs2, rd;
    logic [2:0]  f3;
    logic [31:0] imm;
    logic        we, pcl, asel, bsel, wsel;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    instr_decoder_ij #(.XLEN(32)) uut (
        .instr_i(instr), .rs1_sel_o(rs1), .rs2_sel_o(rs2), .rd_sel_o(rd),
        .funct3_o(f3), .imm_o(imm), .reg_we_o(we), .pc_load_o(pcl),
        .alu_a_sel_o(asel), .alu_b_sel_o(bsel), .wb_sel_o(wsel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s instr=%h actual=%h expected=%h", req, instr, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(posedge clk);
        instr <= w;
        @(negedge clk);
    endtask

    function automatic logic [31:0] enc_jal(input int off, input logic [4:0] rdv);
        logic [20:0] o;
        o = off[20:0];
        return {o[20], o[10:1], o[11], o[19:12], rdv, 7'b1101111};
    endfunction

    task automatic check_jal(input int off);
        apply(enc_jal(off, 5'd3));
        check("R5 offset", imm, off);
        check("R4 strobes", {27'd0, we, pcl, asel, bsel, wsel}, 32'h1F);
    endtask

    initial begin
        logic [31:0] lfsr;
        // reset state: zero word is unrecognised
        apply(32'h0);
        check("R8 reset-word controls", {27'd0, we, pcl, asel, bsel, wsel}, 32'h0);

        // R6 loop-back jump
        apply(32'hFFDFF06F);
        check("R6 minus four", imm, 32'hFFFFFFFC);
        check("R6 encoder agrees", enc_jal(-4, 5'd0), 32'hFFDFF06F);

        // R3/R2 exhaustive add-immediate field
        for (int v = 0; v < 4096; v++) begin
            logic [11:0] iv;
            int          sv;
            iv = v[11:0];
            sv = (v >= 2048) ? v - 4096 : v;
            apply({iv, 5'(v * 7), 3'b000, 5'(v * 3), 7'b0010011});
            check("R3 sign-extended immediate", imm, sv);
            check("R2 add-immediate controls", {27'd0, we, pcl, asel, bsel, wsel}, 32'b10010);
        end

        // R1/R7/R8/R9 every opcode and function field
        for (int op = 0; op < 128; op++) begin
            for (int fn = 0; fn < 8; fn++) begin
                logic [31:0] w;
                logic [4:0]  exp_ctl;
                w = {7'(op * 5 + fn), 5'(op + 11), 5'(op * 3 + fn), 3'(fn), 5'(op ^ 21), 7'(op)};
                apply(w);
                check("R1 rd field", {27'd0, rd}, {27'd0, w[11:7]});
                check("R1 funct3 field", {29'd0, f3}, {29'd0, w[14:12]});
                check("R1 rs1 field", {27'd0, rs1}, {27'd0, w[19:15]});
                check("R1 rs2 field", {27'd0, rs2}, {27'd0, w[24:20]});
                if (op == 7'b1101111)
                    exp_ctl = 5'b11111;
                else if (op == 7'b0010011 && fn == 0)
                    exp_ctl = 5'b10010;
                else
                    exp_ctl = 5'b00000;
                if (op == 7'b1101111)
                    check("R9 jump any funct3", {27'd0, we, pcl, asel, bsel, wsel}, {27'd0, exp_ctl});
                else if (op == 7'b0010011)
                    check("R7 other funct3", {27'd0, we, pcl, asel, bsel, wsel}, {27'd0, exp_ctl});
                else
                    check("R8 other opcode", {27'd0, we, pcl, asel, bsel, wsel}, {27'd0, exp_ctl});
            end
        end

        // R5 single-bit offsets, extremes, pseudo-random
        for (int k = 1; k < 20; k++) begin
            check_jal(1 << k);
            check_jal(-(1 << k));
        end
        check_jal(-(1 << 20));
        check_jal((1 << 20) - 2);
        check_jal(0);
        check_jal(2);
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 300; i++) begin
            int off;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            off = $signed({lfsr[19:0], 12'd0}) >>> 11;
            check_jal(off);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule